// File: doc/BRIEF.md
# Predicate-Result Element Store Controller

This block sits at the write-back end of a vector loop that runs one element per clock. For each element it decides three things: whether the computed result goes to the destination register, whether a fresh condition field is recorded, and whether zero is written to the destination in place of the result. It receives the element index, the element's predicate bit, the result and the mode controls of the current instruction. The element arithmetic and the register files are outside the block.

A test of the newly derived condition field acts as a second, data-dependent predicate. It can cancel the result store, but the condition field is still recorded whenever recording is requested. One zeroing flag drives both source zeroing and destination zeroing. A compare-only mode turns any operation into a pure comparison: only condition fields are written.

All write outputs are registered and appear one clock after the element is presented, tagged with that element's index. The source-zero indication is combinational, because the operand fetch of the same element uses it. The reset is asynchronous and active-low, and the block releases it internally in step with the clock.

Top module: `prs_store_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until an element arrives, `dst_we` and `cf_we` are 0.
- R2: An element presented with `elem_valid`=1 drives its writes on the clock edge that samples it, with `wr_idx` equal to its `elem_idx`. A cycle with `elem_valid`=0 produces `dst_we`=0 and `cf_we`=0 on the next cycle.
- R3: The condition field is 4 bits wide. Bit 3 is set when the result is negative (two's complement), bit 2 when it is positive and nonzero, bit 1 when it is zero, and bit 0 is always 0.
- R4: An element whose predicate bit is 0 causes no destination write and no condition-field write when `zero_flag`=0.
- R5: The condition field is written for an element with predicate 1 whenever `rec_flag`=1 or `cmp_only`=1, whether the test passes or fails. Otherwise it is not written.
- R6: The test selects bit `test_sel` (0..3) of the condition field and passes when that bit equals `test_val`. With predicate 1, `cmp_only`=0 and a passing test, the result is written unchanged to the destination.
- R7: With `cmp_only`=1 the destination is never written, neither with the result nor with zero.
- R8: With `zero_flag`=1 and `cmp_only`=0, an element that is masked out or that fails the test writes zero to the destination.
- R9: `src_zero` is 1 in the same cycle exactly when a valid element has predicate 0 and `zero_flag`=1. Such an element then also gets a destination zero write unless `cmp_only`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| elem_valid | input | 1 | An element is presented this cycle |
| elem_idx | input | IDX_W | Destination element index |
| elem_pred | input | 1 | Predicate bit of the element |
| elem_result | input | DATA_W | Computed element result |
| rec_flag | input | 1 | Record the condition field |
| cmp_only | input | 1 | Compare-only: write condition fields, never results |
| zero_flag | input | 1 | Single zeroing control for source and destination |
| test_sel | input | 2 | Condition-field bit the test examines |
| test_val | input | 1 | Value the selected bit must have for the test to pass |
| src_zero | output | 1 | Source operands of this element read as zero |
| dst_we | output | 1 | Destination register write enable |
| dst_data | output | DATA_W | Destination write data (result or zero) |
| cf_we | output | 1 | Condition-field write enable |
| cf_data | output | 4 | Condition-field write data |
| wr_idx | output | IDX_W | Element index of the registered writes |

## Verification
The bench builds the block with its defaults: 16-bit results and a maximum vector length of 64, so the index is 6 bits. At 16 bits the sign boundary value 0x8000 and the all-ones patterns are cheap to enumerate. This makes the negative, zero and positive condition classes, and every test-bit selection including the always-zero bit, reachable with hand-computed expectations. A six-bit index lets a back-to-back run of ascending elements show that each registered write carries the index of its own element.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int CF_W  = 4;
  localparam int CF_LT = 3;
  localparam int CF_GT = 2;
  localparam int CF_EQ = 1;
  localparam int CF_SO = 0;
  typedef logic [CF_W-1:0] cf_t;
endpackage

// File: rtl/prs_cond_gen.sv
module prs_cond_gen
  import prs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  output cf_t               field
);
  always_comb begin
    field = '0;
    if (value == '0) begin
      field[CF_EQ] = 1'b1;
    end else if (value[DATA_W-1]) begin
      field[CF_LT] = 1'b1;
    end else begin
      field[CF_GT] = 1'b1;
    end
  end
endmodule

// File: rtl/prs_store_decide.sv
module prs_store_decide
  import prs_pkg::*;
(
  input  logic       valid,
  input  logic       pred,
  input  logic       zero_flag,
  input  logic       rec_flag,
  input  logic       cmp_only,
  input  logic [1:0] test_sel,
  input  logic       test_val,
  input  cf_t        field,
  output logic       res_we,
  output logic       res_zero,
  output logic       cf_we,
  output logic       src_zero
);
  logic active;
  logic pass;
  logic store;
  logic zfill;

  always_comb begin
    active   = valid & pred;
    pass     = (field[test_sel] == test_val);
    store    = active & pass & ~cmp_only;
    zfill    = valid & zero_flag & ~cmp_only & (~pred | ~pass);
    res_we   = store | zfill;
    res_zero = zfill;
    cf_we    = active & (rec_flag | cmp_only);
    src_zero = valid & ~pred & zero_flag;
  end

  // R9: a zeroed source always pairs with a zeroed destination unless compare-only
  always_comb begin
    if (src_zero === 1'b1 && cmp_only === 1'b0) begin
      a_r9_src_dst_zero: assert (res_we && res_zero);
    end
  end
endmodule

// File: rtl/prs_store_ctrl.sv
module prs_store_ctrl
  import prs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VL_MAX = 64,
  localparam int IDX_W = $clog2(VL_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              elem_valid,
  input  logic [IDX_W-1:0]  elem_idx,
  input  logic              elem_pred,
  input  logic [DATA_W-1:0] elem_result,
  input  logic              rec_flag,
  input  logic              cmp_only,
  input  logic              zero_flag,
  input  logic [1:0]        test_sel,
  input  logic              test_val,
  output logic              src_zero,
  output logic              dst_we,
  output logic [DATA_W-1:0] dst_data,
  output logic              cf_we,
  output logic [CF_W-1:0]   cf_data,
  output logic [IDX_W-1:0]  wr_idx
);
  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cf_t  field;
  logic res_we_d;
  logic res_zero_d;
  logic cf_we_d;

  prs_cond_gen #(.DATA_W(DATA_W)) u_cond (
    .value (elem_result),
    .field (field)
  );

  prs_store_decide u_decide (
    .valid     (elem_valid),
    .pred      (elem_pred),
    .zero_flag (zero_flag),
    .rec_flag  (rec_flag),
    .cmp_only  (cmp_only),
    .test_sel  (test_sel),
    .test_val  (test_val),
    .field     (field),
    .res_we    (res_we_d),
    .res_zero  (res_zero_d),
    .cf_we     (cf_we_d),
    .src_zero  (src_zero)
  );

  // next-state
  logic [DATA_W-1:0] dst_data_d;
  logic              load_en;

  always_comb begin
    load_en    = elem_valid;
    dst_data_d = res_zero_d ? '0 : elem_result;
  end

  // enables update every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dst_we <= 1'b0;
      cf_we  <= 1'b0;
    end else begin
      dst_we <= res_we_d;
      cf_we  <= cf_we_d;
    end
  end

  // payload registers, clock-enabled by a valid element
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dst_data <= '0;
      cf_data  <= '0;
      wr_idx   <= '0;
    end else if (load_en) begin
      dst_data <= dst_data_d;
      cf_data  <= field;
      wr_idx   <= elem_idx;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |=> !dst_we && !cf_we);

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !elem_valid |=> !dst_we && !cf_we);

  a_r2_index_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    elem_valid |=> wr_idx == $past(elem_idx));

  a_r3_field_shape: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cf_we |-> $onehot(cf_data[3:1]) && !cf_data[0]);

  a_r4_masked_skip: assert property (@(posedge clk) disable iff (!rst_sync_n)
    elem_valid && !elem_pred && !zero_flag |=> !dst_we && !cf_we);

  a_r5_record: assert property (@(posedge clk) disable iff (!rst_sync_n)
    elem_valid && elem_pred && (rec_flag || cmp_only) |=> cf_we);

  a_r7_cmp_no_dst: assert property (@(posedge clk) disable iff (!rst_sync_n)
    elem_valid && cmp_only |=> !dst_we);

  a_r8_masked_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    elem_valid && !elem_pred && zero_flag && !cmp_only |=> dst_we && dst_data == '0);
endmodule

// File: tb/prs_store_ctrl_tb.sv
module prs_store_ctrl_tb;
  localparam int DATA_W = 16;
  localparam int VL_MAX = 64;
  localparam int IDX_W  = $clog2(VL_MAX);
  localparam int NVEC   = 13;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              elem_valid;
  logic [IDX_W-1:0]  elem_idx;
  logic              elem_pred;
  logic [DATA_W-1:0] elem_result;
  logic              rec_flag;
  logic              cmp_only;
  logic              zero_flag;
  logic [1:0]        test_sel;
  logic              test_val;
  logic              src_zero;
  logic              dst_we;
  logic [DATA_W-1:0] dst_data;
  logic              cf_we;
  logic [3:0]        cf_data;
  logic [IDX_W-1:0]  wr_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  prs_store_ctrl #(.DATA_W(DATA_W), .VL_MAX(VL_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_idx(elem_idx),
    .elem_pred(elem_pred), .elem_result(elem_result), .rec_flag(rec_flag),
    .cmp_only(cmp_only), .zero_flag(zero_flag), .test_sel(test_sel),
    .test_val(test_val), .src_zero(src_zero), .dst_we(dst_we),
    .dst_data(dst_data), .cf_we(cf_we), .cf_data(cf_data), .wr_idx(wr_idx)
  );

  // {pred,zero,rec,cmp,sel[2],tval,result[16], exp_we,exp_data[16],exp_cfwe,exp_cf[4]}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b0,1'b0,2'd1,1'b1,16'h0000, 1'b1,16'h0000,1'b0,4'b0010},
    {1'b1,1'b0,1'b1,1'b0,2'd1,1'b1,16'h0005, 1'b0,16'h0000,1'b1,4'b0100},
    {1'b1,1'b1,1'b1,1'b0,2'd1,1'b1,16'h0005, 1'b1,16'h0000,1'b1,4'b0100},
    {1'b0,1'b0,1'b1,1'b0,2'd2,1'b1,16'h0005, 1'b0,16'h0000,1'b0,4'b0000},
    {1'b0,1'b1,1'b1,1'b0,2'd2,1'b1,16'h0005, 1'b1,16'h0000,1'b0,4'b0000},
    {1'b1,1'b0,1'b0,1'b1,2'd2,1'b1,16'h0005, 1'b0,16'h0000,1'b1,4'b0100},
    {1'b1,1'b1,1'b0,1'b1,2'd2,1'b0,16'h0005, 1'b0,16'h0000,1'b1,4'b0100},
    {1'b1,1'b0,1'b1,1'b0,2'd3,1'b1,16'hFFF0, 1'b1,16'hFFF0,1'b1,4'b1000},
    {1'b1,1'b0,1'b0,1'b0,2'd3,1'b0,16'h0007, 1'b1,16'h0007,1'b0,4'b0000},
    {1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,16'hFFF0, 1'b1,16'hFFF0,1'b0,4'b0000},
    {1'b1,1'b1,1'b0,1'b0,2'd0,1'b1,16'h0003, 1'b1,16'h0000,1'b0,4'b0000},
    {1'b0,1'b1,1'b0,1'b1,2'd0,1'b0,16'h0005, 1'b0,16'h0000,1'b0,4'b0000},
    {1'b1,1'b0,1'b1,1'b0,2'd2,1'b0,16'h8000, 1'b1,16'h8000,1'b1,4'b1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    elem_valid = 1'b0; elem_idx = '0; elem_pred = 1'b0; elem_result = '0;
    rec_flag = 1'b0; cmp_only = 1'b0; zero_flag = 1'b0; test_sel = 2'd0; test_val = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dst_we in reset", 32'(dst_we), 0);
    chk("R1 cf_we in reset", 32'(cf_we), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 dst_we after release", 32'(dst_we), 0);
    chk("R1 cf_we after release", 32'(cf_we), 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [44:0] v;
      v = VEC[i];
      elem_valid  = 1'b1;
      elem_idx    = IDX_W'(i + 5);
      elem_pred   = v[44];
      zero_flag   = v[43];
      rec_flag    = v[42];
      cmp_only    = v[41];
      test_sel    = v[40:39];
      test_val    = v[38];
      elem_result = v[37:22];
      #1;
      chk("R9 src_zero", 32'(src_zero), 32'(~v[44] & v[43]));
      @(negedge clk);
      elem_valid = 1'b0;
      chk($sformatf("R6/R7/R8/R4 dst_we vec %0d", i), 32'(dst_we), 32'(v[21]));
      if (v[21]) chk($sformatf("R6/R8 dst_data vec %0d", i), 32'(dst_data), 32'(v[20:5]));
      chk($sformatf("R5 cf_we vec %0d", i), 32'(cf_we), 32'(v[4]));
      if (v[4]) chk($sformatf("R3 cf_data vec %0d", i), 32'(cf_data), 32'(v[3:0]));
      chk($sformatf("R2 wr_idx vec %0d", i), 32'(wr_idx), 32'(i + 5));
    end

    // R2: idle cycle with otherwise writing controls
    idle_inputs();
    elem_pred = 1'b1; rec_flag = 1'b1; zero_flag = 1'b1; elem_result = 16'h0001;
    @(negedge clk);
    chk("R2 idle dst_we", 32'(dst_we), 0);
    chk("R2 idle cf_we", 32'(cf_we), 0);

    // R2: back-to-back ascending elements, each write tagged with its own index
    for (int k = 0; k < 4; k++) begin
      elem_valid = 1'b1; elem_idx = IDX_W'(k); elem_pred = 1'b1;
      rec_flag = 1'b1; cmp_only = 1'b0; zero_flag = 1'b0;
      test_sel = 2'd2; test_val = 1'b1; elem_result = 16'(k + 1);
      @(negedge clk);
      chk("R2 stream wr_idx", 32'(wr_idx), 32'(k));
      chk("R6 stream dst_data", 32'(dst_data), 32'(k + 1));
      chk("R3 stream cf_data", 32'(cf_data), 32'h4);
    end
    elem_valid = 1'b0;
    @(negedge clk);
    chk("R2 stream end dst_we", 32'(dst_we), 0);

    // R1: reset mid-stream clears enables
    elem_valid = 1'b1; elem_pred = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R1 async clear dst_we", 32'(dst_we), 0);
    chk("R1 async clear cf_we", 32'(cf_we), 0);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule